// File: doc/BRIEF.md
# Saturating Channel Overflow Status Register

This block sits at the end of a six-channel audio output path. Each channel is organised as one of three pairs, with an A and a B side. Every output sample arrives one bit wider than the output word. The block clamps it to the positive or negative full-scale code, registers the clamped result, and records each clamp in a sticky status byte. A host reads that byte through a read strobe.

The `edge_mode_i` input selects how the interrupt behaves. In edge mode, a host read clears the status byte and the interrupt is a one-cycle pulse for each bit that newly sets. In level mode, a read leaves the byte unchanged and the interrupt stays high while any bit is set. A mask input gates only the interrupt request. The status bits are recorded the same way whether or not the mask is set, so the host can poll them instead of taking the interrupt.

Top module: `ovfl_status_top`

## Requirements
- R1: A sample of 25 bits (two's complement) above +0x7FFFFF is output as 0x7FFFFF. An in-range sample is output unchanged. `smp_o` updates one cycle after a cycle with `smp_vld_i` high and holds otherwise.
- R2: A sample below -0x800000 is output as 0x800000.
- R3: A clamp on channel k with `smp_vld_i` high sets status bit k on the next clock edge. The layout is bit0 A1, bit1 B1, bit2 A2, bit3 B2, bit4 A3, bit5 B3. Channel k occupies bits [25k+24:25k] of `smp_i` and bits [24k+23:24k] of `smp_o`.
- R4: A set status bit stays set until a clearing read.
- R5: With `edge_mode_i`=1, a cycle with `rd_i` high clears all status bits on the next edge. `rd_data_o` always shows the current status.
- R6: With `edge_mode_i`=0, `rd_i` has no effect on the status bits.
- R7: A clamp that occurs in the same cycle as a clearing read leaves its bit set.
- R8: `irq_mask_i` has no effect on the status bits.
- R9: After reset, all status bits and `irq_o` are 0. Bits 7:6 of `rd_data_o` always read 0.
- R10: With `edge_mode_i`=0, `irq_o` is high exactly when any status bit is set and `irq_mask_i` is 0.
- R11: With `edge_mode_i`=1, `irq_o` is high for one cycle, in the cycle after a clock edge on which any status bit went from 0 to 1, provided `irq_mask_i` was 0 before that edge.
- R12: When `irq_mask_i` is 1, no interrupt is raised in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Samples valid this cycle |
| smp_i | input | 150 | Six wide samples, 25 bits each |
| smp_o | output | 144 | Six clamped samples, 24 bits each, registered |
| rd_i | input | 1 | Host read strobe for the status byte |
| rd_data_o | output | 8 | Status byte |
| edge_mode_i | input | 1 | 1 selects edge interrupt and clear-on-read, 0 selects level |
| irq_mask_i | input | 1 | 1 blocks the interrupt request |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can land on the same clock edge: a host read that clears the byte, and a fresh clamp that sets one of its bits. The bench provokes this by driving `rd_i` in edge mode while an out-of-range sample is valid. It does this both on a channel whose bit is already set and on one whose bit is clear. The expected byte on the next cycle is the clamped-channel bit alone, and the interrupt pulse is expected only where that bit was clear before the edge.

// File: rtl/ovfl_pkg.sv
package ovfl_pkg;
  typedef enum logic {
    IRQ_LEVEL = 1'b0,
    IRQ_EDGE  = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/ovfl_sat.sv
module ovfl_sat #(
  parameter int unsigned SW = 24
) (
  input  logic [SW:0]   in_i,
  output logic [SW-1:0] out_o,
  output logic          clip_o
);
  // top two bits disagree: value does not fit in SW bits
  assign clip_o = in_i[SW] ^ in_i[SW-1];
  assign out_o  = clip_o ? {in_i[SW], {(SW-1){~in_i[SW]}}} : in_i[SW-1:0];
endmodule

// File: rtl/ovfl_sticky.sv
module ovfl_sticky #(
  parameter int unsigned NCH = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vld_i,
  input  logic [NCH-1:0] clip_i,
  input  logic           clr_i,
  output logic [NCH-1:0] status_o,
  output logic           rise_o
);
  logic [NCH-1:0] status_q, status_d, hit;

  assign hit = vld_i ? clip_i : '0;
  // new events win over the clear
  assign status_d = (clr_i ? '0 : status_q) | hit;
  assign rise_o   = |(status_d & ~status_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o = status_q;

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && clip_i[i]) |=> status_q[i]);
    a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_q[i] && !clr_i) |=> status_q[i]);
    a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !(vld_i && clip_i[i])) |=> !status_q[i]);
    a_r7_keep_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && vld_i && clip_i[i]) |=> status_q[i]);
  end
endmodule

// File: rtl/ovfl_irq.sv
module ovfl_irq
  import ovfl_pkg::*;
#(
  parameter int unsigned NCH = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] status_i,
  input  logic           rise_i,
  input  irq_mode_e      mode_i,
  input  logic           mask_i,
  output logic           irq_o
);
  logic pulse_q, level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= rise_i & ~mask_i;
  end

  assign level = (|status_i) & ~mask_i;
  assign irq_o = (mode_i == IRQ_EDGE) ? pulse_q : level;

  a_r10_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == IRQ_LEVEL && !mask_i && (|status_i)) |-> irq_o);
  a_r11_pulse_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> ((status_i & ~$past(status_i)) != '0));
  a_r12_mask_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |=> !pulse_q);
  a_r12_mask_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i && mode_i == IRQ_LEVEL) |-> !irq_o);
endmodule

// File: rtl/ovfl_status_top.sv
module ovfl_status_top
  import ovfl_pkg::*;
#(
  parameter int unsigned PAIRS    = 3,
  parameter int unsigned SW       = 24,
  parameter int unsigned STATUS_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        smp_vld_i,
  input  logic [2*PAIRS*(SW+1)-1:0]   smp_i,
  output logic [2*PAIRS*SW-1:0]       smp_o,
  input  logic                        rd_i,
  output logic [STATUS_W-1:0]         rd_data_o,
  input  logic                        edge_mode_i,
  input  logic                        irq_mask_i,
  output logic                        irq_o
);
  localparam int unsigned NCH = 2 * PAIRS;
  localparam int unsigned IW  = SW + 1;
  localparam logic [SW-1:0] FS_POS = {1'b0, {(SW-1){1'b1}}};
  localparam logic [SW-1:0] FS_NEG = {1'b1, {(SW-1){1'b0}}};

  logic [NCH-1:0] clip, status;
  logic           rise, clr;
  irq_mode_e      mode;

  assign mode = irq_mode_e'(edge_mode_i);
  assign clr  = rd_i & (mode == IRQ_EDGE);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [SW-1:0] sat, smp_q;

    ovfl_sat #(.SW(SW)) u_sat (
      .in_i  (smp_i[k*IW +: IW]),
      .out_o (sat),
      .clip_o(clip[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        smp_q <= '0;
      else if (smp_vld_i) smp_q <= sat;
    end

    assign smp_o[k*SW +: SW] = smp_q;

    a_r1_r2_full_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_vld_i && clip[k]) |=>
        (smp_q == ($past(smp_i[k*IW + SW]) ? FS_NEG : FS_POS)));
  end

  ovfl_sticky #(.NCH(NCH)) u_sticky (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (smp_vld_i),
    .clip_i  (clip),
    .clr_i   (clr),
    .status_o(status),
    .rise_o  (rise)
  );

  ovfl_irq #(.NCH(NCH)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .status_i(status),
    .rise_i  (rise),
    .mode_i  (mode),
    .mask_i  (irq_mask_i),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[NCH-1:0] = status;
  end

  if (STATUS_W > NCH) begin : g_rsv
    a_r9_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o[STATUS_W-1:NCH] == '0);
  end

  a_r6_level_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == IRQ_LEVEL) |=> ((status & $past(status)) == $past(status)));
endmodule

// File: tb/ovfl_status_top_tb.sv
module ovfl_status_top_tb;
  localparam int SW  = 24;
  localparam int IW  = 25;
  localparam int NCH = 6;

  logic               clk = 0;
  logic               rst_n = 0;
  logic               vld = 0, rd = 0, edge_m = 0, mask = 0;
  logic [NCH*IW-1:0]  smp_i = '0;
  logic [NCH*SW-1:0]  smp_o;
  logic [7:0]         rd_data;
  logic               irq;

  int total = 0, bad = 0, cyc = 0;

  typedef struct {
    int          at;
    int          kind;
    int          idx;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  logic signed [IW-1:0] in_s [NCH];
  logic [SW-1:0]        out_m [NCH];
  logic [7:0]           st_m = 0;
  logic                 pulse_m = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ovfl_status_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_i(smp_i), .smp_o(smp_o),
    .rd_i(rd), .rd_data_o(rd_data), .edge_mode_i(edge_m), .irq_mask_i(mask), .irq_o(irq)
  );

  function automatic logic [SW-1:0] clamp(logic signed [IW-1:0] v);
    if (v > 25'sd8388607)       return 24'h7FFFFF;
    else if (v < -25'sd8388608) return 24'h800000;
    else                        return v[SW-1:0];
  endfunction

  function automatic logic is_clip(logic signed [IW-1:0] v);
    return (v > 25'sd8388607) || (v < -25'sd8388608);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // driver: one cycle of stimulus, expected results go into the scoreboard
  task automatic drive(logic v, logic r, logic e, logic m, string req);
    logic [7:0] clipv, nxt;
    item_t it;
    @(negedge clk);
    vld = v; rd = r; edge_m = e; mask = m;
    for (int k = 0; k < NCH; k++) smp_i[k*IW +: IW] = in_s[k];
    clipv = '0;
    for (int k = 0; k < NCH; k++) clipv[k] = v && is_clip(in_s[k]);
    nxt = ((r && e) ? 8'h00 : st_m) | clipv;
    it = '{cyc, 1, 0, {31'd0, e ? pulse_m : ((|st_m) && !m)}, req};
    sb.push_back(it);
    it = '{cyc + 1, 0, 0, {24'd0, nxt}, req};
    sb.push_back(it);
    if (v) for (int k = 0; k < NCH; k++) out_m[k] = clamp(in_s[k]);
    for (int k = 0; k < NCH; k++) begin
      it = '{cyc + 1, 2, k, {8'd0, out_m[k]}, req};
      sb.push_back(it);
    end
    pulse_m = (|(nxt & ~st_m)) && !m;
    st_m = nxt;
  endtask

  task automatic set_all(logic signed [IW-1:0] v);
    for (int k = 0; k < NCH; k++) in_s[k] = v;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0 && sb[0].at <= cyc) begin
        item_t it;
        it = sb.pop_front();
        case (it.kind)
          0: check(it.req, {24'd0, rd_data}, it.exp, "status byte");
          1: check(it.req, {31'd0, irq}, it.exp, "irq");
          default: check(it.req, {8'd0, smp_o[it.idx*SW +: SW]}, it.exp, "sample");
        endcase
      end
    end
  end

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    set_all(0);
    for (int k = 0; k < NCH; k++) out_m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check("R9", {24'd0, rd_data}, 0, "reset status");
    check("R9", {31'd0, irq}, 0, "reset irq");

    // R1 in-range pass-through, level mode
    in_s[0] = 25'sd8388607; in_s[1] = -25'sd8388608; in_s[2] = 25'sd1234;
    in_s[3] = -25'sd77; in_s[4] = 0; in_s[5] = 25'sd4000000;
    drive(1, 0, 0, 0, "R1");
    drive(0, 0, 0, 0, "R1");
    // R1/R3 positive overflow on A1 (bit0)
    set_all(25'sd5);
    in_s[0] = 25'sd8388608;
    drive(1, 0, 0, 0, "R3");
    set_all(-25'sd3);
    drive(1, 0, 0, 0, "R1");
    // R2 negative overflow on B3 (bit5), R10 level irq
    in_s[5] = -25'sd8388609;
    drive(1, 0, 0, 0, "R2");
    // R4 holds while idle, samples hold without valid
    in_s[5] = 25'sd9;
    drive(0, 0, 0, 0, "R4");
    drive(0, 0, 0, 0, "R4");
    drive(1, 0, 0, 0, "R10");
    // R6 read in level mode keeps bits
    drive(0, 1, 0, 0, "R6");
    drive(0, 1, 0, 0, "R6");
    // R8/R12 mask: status still records B2 (bit3), irq held low
    set_all(0); in_s[3] = 25'sh0FFFFFF;
    drive(1, 0, 0, 1, "R8");
    set_all(0);
    drive(0, 0, 0, 1, "R12");
    drive(0, 0, 0, 0, "R10");
    // R5 edge mode read clears
    drive(0, 0, 1, 0, "R5");
    drive(0, 1, 1, 0, "R5");
    drive(0, 0, 1, 0, "R5");
    // R11 new clip on A2 (bit2) yields a single pulse
    in_s[2] = -25'sd16777216;
    drive(1, 0, 1, 0, "R11");
    set_all(0);
    drive(1, 0, 1, 0, "R11");
    drive(0, 0, 1, 0, "R11");
    // R7 read together with clip on set bit (A2) and clear bit (B1)
    in_s[2] = 25'sd9000000; in_s[1] = 25'sd9000000;
    drive(1, 1, 1, 0, "R7");
    set_all(0);
    drive(0, 0, 1, 0, "R7");
    in_s[4] = -25'sd9000000;
    drive(1, 1, 1, 0, "R7");
    set_all(0);
    drive(0, 0, 1, 0, "R7");
    // R12 edge mode with mask: bits set, no pulse
    drive(0, 1, 1, 0, "R12");
    in_s[0] = 25'sd8388608;
    drive(1, 0, 1, 1, "R12");
    set_all(0);
    drive(0, 0, 1, 0, "R12");
    // R3 all channels, alternating signs
    drive(0, 1, 1, 0, "R3");
    for (int k = 0; k < NCH; k++) in_s[k] = (k % 2) ? -25'sd10000000 : 25'sd10000000;
    drive(1, 0, 1, 0, "R3");
    set_all(0);
    drive(0, 0, 1, 0, "R3");
    drive(0, 0, 0, 0, "R9");
    drive(0, 0, 0, 0, "R9");
    repeat (3) @(negedge clk);
    #3;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule